// File: doc/BRIEF.md
# Pulse-Width Counting ADC Controller

This block holds the digital half of a fixed-rate counting converter. A free-running divider splits the master clock into sample periods of a fixed number of cycles. At the start of each period it pulses a ramp-start output and sets a conversion window flag. An external ramp is compared against the held analog input. When the ramp reaches the input, the comparator raises its output, and that rising edge closes the window. While the window is open, every clock edge advances a saturating binary counter. The count is therefore proportional to the input.

At the next period boundary the finished count is copied to a registered result with a one-cycle valid strobe, and the counter restarts from zero. The comparator signal is treated as asynchronous. It passes through a two-flop synchronizer and then an edge detector, so a comparator that stays high closes the window only once. The period length and the counter width are parameters, with defaults of 100 cycles and 5 bits. With those defaults a count of 31 is full scale.

Top module: `pwm_count_adc`

## Requirements
- R1: With `rst` low, `rampStart` is high for exactly one cycle in every DIV_RATIO cycles (default 100). The first pulse is visible DIV_RATIO-1 cycles after `rst` is released.
- R2: The clock edge that ends a `rampStart` cycle sets the window, so `gateOut` is high in the following cycle.
- R3: A rising edge of `cmpIn` that is first sampled at clock edge k clears `gateOut` at edge k+2. This is two synchronizer stages followed by an edge detector.
- R4: Within a sample period, the count increases by one at each clock edge where `gateOut` is high. If `cmpIn` rises d cycles after the ramp-start cycle, the result is d+2.
- R5: The count saturates at 2^CNT_W-1 (31 by default) instead of wrapping, including when no comparator edge arrives at all.
- R6: At each sample edge, the finished count is loaded into `dataOut` and `dataValid` is high for exactly one cycle. The counter restarts from zero at that edge.
- R7: A `cmpIn` level held high closes the window only once. In the next sample period the window stays open and the result saturates.
- R8: When a comparator edge and a sample edge fall on the same clock edge, the set wins and the window stays open for the new period.
- R9: A synchronous active-high `rst` clears the divider, window, counter, synchronizer and result. `gateOut`, `dataOut` and `dataValid` read 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpIn | input | 1 | Asynchronous comparator output, high once the ramp reaches the input |
| rampStart | output | 1 | One-cycle pulse that starts the external ramp and opens the window |
| gateOut | output | 1 | Conversion window; counted clocks are those where this is high |
| dataOut | output | CNT_W | Result of the last finished sample period |
| dataValid | output | 1 | One-cycle strobe when `dataOut` is updated |

## Verification
The hardest case to reach is the collision of a comparator edge with the sample edge. At that edge the window must be both cleared and set, and the set must win. The bench reaches it by raising `cmpIn` exactly 98 cycles after the ramp-start cycle, which accounts for the two synchronizer stages and the edge detector. It then checks that `gateOut` is still high in the next period and that the next result has the expected full width. A comparator held high across a boundary is also driven deliberately, to show that the edge detector does not close the window a second time.

// File: rtl/pwmadc_pkg.sv
package pwmadc_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic sample;   // period boundary: load result, restart count
    logic gate;     // conversion window open
  } ctlStrobes_t;
endpackage

// File: rtl/pwmadc_ctl.sv
module pwmadc_ctl
  import pwmadc_pkg::*;
#(
  parameter int DIV_RATIO   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmpIn,
  output ctlStrobes_t strobes,
  output logic        rampStart
);
  localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);

  logic [DIV_W-1:0]     divCnt;
  logic [SYNC_STAGES:0] syncQ;
  logic                 sampleNow;
  logic                 cmpEdge;
  logic                 gateQ;

  // period divider
  always_ff @(posedge clk) begin
    if (rst)                   divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                       divCnt <= divCnt + 1'b1;
  end
  assign sampleNow = (divCnt == DIV_LAST);

  // synchronizer chain plus one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[SYNC_STAGES-1:0], cmpIn};
  end
  assign cmpEdge = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // window latch: set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)            gateQ <= 1'b0;
    else if (sampleNow) gateQ <= 1'b1;
    else if (cmpEdge)   gateQ <= 1'b0;
  end

  assign strobes.sample = sampleNow;
  assign strobes.gate   = gateQ;
  assign rampStart      = sampleNow;

  // R1
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    divCnt <= DIV_LAST);
  // R2
  gate_set_chk: assert property (@(posedge clk) disable iff (rst)
    sampleNow |=> gateQ);
  // R3
  gate_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmpEdge && !sampleNow && gateQ) |=> !gateQ);
  // R7
  edge_once_chk: assert property (@(posedge clk) disable iff (rst)
    cmpEdge |=> !cmpEdge);
endmodule

// File: rtl/pwmadc_dp.sv
module pwmadc_dp
  import pwmadc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobes_t      strobes,
  output logic [CNT_W-1:0] dataOut,
  output logic             dataValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  // gated, saturating counter
  always_ff @(posedge clk) begin
    if (rst)                               cnt <= '0;
    else if (strobes.sample)               cnt <= '0;
    else if (strobes.gate && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // result register
  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strobes.sample;
      if (strobes.sample) dataOut <= cnt;
    end
  end

  // R4
  cnt_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.sample |=> cnt >= $past(cnt));
  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !strobes.sample) |=> cnt == CNT_MAX);
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid);
endmodule

// File: rtl/pwm_count_adc.sv
module pwm_count_adc
  import pwmadc_pkg::*;
#(
  parameter int DIV_RATIO = 100,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmpIn,
  output logic             rampStart,
  output logic             gateOut,
  output logic [CNT_W-1:0] dataOut,
  output logic             dataValid
);
  ctlStrobes_t strobes;

  pwmadc_ctl #(.DIV_RATIO(DIV_RATIO), .SYNC_STAGES(2)) uCtl (
    .clk(clk), .rst(rst), .cmpIn(cmpIn),
    .strobes(strobes), .rampStart(rampStart)
  );

  pwmadc_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  assign gateOut = strobes.gate;

  // R6
  valid_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    rampStart |=> dataValid);
endmodule

// File: tb/sim_pwm_count_adc.sv
module sim_pwm_count_adc;
  localparam int DIV = 100;
  localparam int CW  = 5;
  localparam int FULL = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmpIn = 1'b0;
  logic rampStart, gateOut, dataValid;
  logic [CW-1:0] dataOut;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;
  int expQ[$];
  string tagQ[$];
  bit seen = 0;
  int gap = 0;

  always #10 clk = ~clk;

  pwm_count_adc #(.DIV_RATIO(DIV), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .cmpIn(cmpIn), .rampStart(rampStart),
    .gateOut(gateOut), .dataOut(dataOut), .dataValid(dataValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // result and period monitor
  always @(negedge clk) begin
    if (rst) begin
      seen = 0;
      gap = 0;
    end else begin
      gap = gap + 1;
      if (rampStart) begin
        if (seen) check(gap == DIV, "R1 period", gap, DIV);
        seen = 1;
        gap = 0;
      end
      if (dataValid) begin
        if (expQ.size() == 0) check(0, "R6 unexpected valid", int'(dataOut), -1);
        else begin
          automatic int e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(int'(dataOut) == e, t, int'(dataOut), e);
        end
      end
    end
  end

  // one sample period; call at the negedge where rampStart is high
  // d<0: no comparator rise; hold==0: keep cmpIn high
  task automatic doPeriod(input int d, input int hold, input int exp,
                          input bit clr, input string tag);
    if (clr) cmpIn = 1'b0;
    if (d == 0) cmpIn = 1'b1;
    for (int i = 1; i < 4 * DIV; i++) begin
      @(negedge clk);
      if (i == 1) check(gateOut == 1'b1, "R2 gate open", int'(gateOut), 1);
      if (rampStart) break;
      if (d > 0 && i == d) cmpIn = 1'b1;
      if (d >= 0 && hold > 0 && i == d + hold) cmpIn = 1'b0;
    end
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic waitRamp(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rampStart && n < 4 * DIV);
  endtask

  // {delay after ramp-start cycle, expected result}  (R3, R4, R5)
  localparam int VEC[8][2] = '{
    '{0, 2}, '{1, 3}, '{5, 7}, '{12, 14},
    '{28, 30}, '{29, 31}, '{40, 31}, '{90, 31}
  };

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(gateOut == 0, "R9 gate", int'(gateOut), 0);
    check(dataValid == 0, "R9 valid", int'(dataValid), 0);
    check(dataOut == 0, "R9 data", int'(dataOut), 0);
    rst = 1'b0;
    waitRamp(n);
    check(n == DIV - 1, "R1 first pulse", n, DIV - 1);
    expQ.push_back(0); tagQ.push_back("R9 first result");

    for (int v = 0; v < 8; v++) begin
      doPeriod(VEC[v][0], 3, VEC[v][1], 1'b1, "R4 vector");
    end

    // R7: level held high closes the window once; next period saturates
    doPeriod(5, 0, 7, 1'b1, "R7 first close");
    doPeriod(-1, 0, FULL, 1'b0, "R7 held level");
    // R5: no comparator edge at all
    doPeriod(-1, 0, FULL, 1'b1, "R5 no edge");
    // R8: comparator clear lands on the sample edge
    doPeriod(98, 0, FULL, 1'b1, "R8 collide");
    doPeriod(5, 3, 7, 1'b1, "R8 next period");
    doPeriod(20, 3, 22, 1'b1, "R6 before reset");

    // R9: mid-period reset
    cmpIn = 1'b0;
    repeat (10) @(negedge clk);
    check(dataOut == 22, "R6 held result", int'(dataOut), 22);
    rst = 1'b1;
    @(negedge clk);
    check(gateOut == 0, "R9 mid gate", int'(gateOut), 0);
    check(dataOut == 0, "R9 mid data", int'(dataOut), 0);
    check(dataValid == 0, "R9 mid valid", int'(dataValid), 0);
    check(rampStart == 0, "R9 mid divider", int'(rampStart), 0);
    expQ.delete(); tagQ.delete();
    rst = 1'b0;
    waitRamp(n);
    check(n == DIV - 1, "R9 divider restart", n, DIV - 1);
    expQ.push_back(0); tagQ.push_back("R9 cleared count");
    doPeriod(10, 3, 12, 1'b1, "R4 after reset");

    cmpIn = 1'b0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R6 results pending", expQ.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule